// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounder

This block is the rounding step of a floating-point result path, and it is purely combinational. It takes a sign, a mantissa, a separate sticky bit and a 2-bit rounding-mode selector. The two lowest mantissa bits are the guard bit (upper) and the round bit (lower). The block always discards those two bits. It then decides from the mode, the sign and the discarded information whether the remaining field must be incremented. The increment carries through the whole field.

The caller reserves headroom bits above the leading one of the mantissa. An increment can therefore carry into the next power of two; for a normalised input this gives the value 2.0. The block does not renormalise that result. It reports the increment on a rounded-up output, so the packer can adjust the exponent. A second output depends only on the mode and the sign. It tells the caller whether an overflowing result should saturate to infinity or to the largest finite magnitude.

Parameters choose the mantissa width and the incrementer structure: a plain ripple chain, or a chunked carry-skip in which whole all-ones chunks forward the carry.

Top module: `mant_round`

## Requirements
- R1: `rounded_o` equals `mant_i` shifted right by 2, plus the increment decision. The sum wraps modulo 2^(MANT_W-2).
- R2: When `mant_i[1]`, `mant_i[0]` and `sticky_i` are all 0, there is no increment and `inexact_o` is 0, in every mode.
- R3: When any of `mant_i[1]`, `mant_i[0]` or `sticky_i` is 1, `inexact_o` is 1, in every mode and for either sign.
- R4: With `rmode_i` = 0 (nearest), the block increments exactly when `mant_i[1]` is 1 and at least one of these holds: `mant_i[0]` is 1, `sticky_i` is 1, or `mant_i[2]` is 1. A tie therefore rounds to even.
- R5: With `rmode_i` = 1 (toward zero), the block never increments.
- R6: With `rmode_i` = 2 (toward +infinity), an inexact value increments only when `sign_i` is 0. With `rmode_i` = 3 (toward -infinity), it increments only when `sign_i` is 1.
- R7: The increment carries across the full output width. For example, 0x7FFFFF becomes 0x800000 and 0xFFFFFF wraps to 0. The carry-out case is left uncorrected.
- R8: `ovf_inf_o` is 1 in mode 0 and 0 in mode 1. In mode 2 it equals NOT `sign_i`, and in mode 3 it equals `sign_i`. It does not depend on the mantissa.
- R9: `rnd_up_o` is 1 exactly when an increment was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mant_i | input | MANT_W | Mantissa; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits below the round bit |
| rmode_i | input | 2 | 0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf |
| rounded_o | output | MANT_W-2 | Rounded mantissa, not renormalised |
| rnd_up_o | output | 1 | An increment was applied |
| inexact_o | output | 1 | Discarded bits were non-zero |
| ovf_inf_o | output | 1 | Overflow goes to infinity (1) or to the largest finite value (0) |

## Verification
Immediate assertions are evaluated whenever an input changes. They check the following invariants:
- an exact value never increments;
- toward-zero never increments;
- a directed mode never increments against its sign;
- the incrementer output equals the shifted field plus the decision flag;
- a carry-out leaves a zero field;
- the overflow direction agrees with the mode in its two fixed cases.

Some behaviour only the bench scenarios can show. These are the exact tie-to-even outcomes for both LSB parities, the required increment under each mode and sign, and the concrete results of long carry runs such as 0x7FFFFF and 0xFFFFFF.

// File: rtl/mant_round_pkg.sv
package mant_round_pkg;

   typedef enum logic [1:0] {
      RMODE_NEAREST = 2'd0,
      RMODE_ZERO    = 2'd1,
      RMODE_POS     = 2'd2,
      RMODE_NEG     = 2'd3
   } rmode_e;

   // Incrementer structures selectable by parameter
   localparam int INC_RIPPLE = 0;
   localparam int INC_SKIP   = 1;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
   import mant_round_pkg::*;
(
   input  logic       sign_i,
   input  logic       guard_i,
   input  logic       round_i,
   input  logic       sticky_i,
   input  logic       lsb_i,
   input  logic [1:0] rmode_i,
   output logic       bump_o,
   output logic       inexact_o
);

   logic   lost;
   rmode_e mode;

   assign mode      = rmode_e'(rmode_i);
   assign lost      = guard_i | round_i | sticky_i;
   assign inexact_o = lost;

   always_comb begin
      bump_o = 1'b0;
      unique case (mode)
         RMODE_NEAREST: bump_o = guard_i & (round_i | sticky_i | lsb_i);
         RMODE_ZERO:    bump_o = 1'b0;
         RMODE_POS:     bump_o = lost & ~sign_i;
         RMODE_NEG:     bump_o = lost & sign_i;
         default:       bump_o = guard_i & (round_i | sticky_i | lsb_i);
      endcase
   end

   always_comb begin
      AST_EXACT_HOLDS: assert (lost || !bump_o);                       // R2
      AST_ZERO_MODE:   assert (mode != RMODE_ZERO || !bump_o);         // R5
      AST_POS_SIGN:    assert (!(mode == RMODE_POS && sign_i) || !bump_o); // R6
      AST_NEG_SIGN:    assert (!(mode == RMODE_NEG && !sign_i) || !bump_o); // R6
   end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr
   import mant_round_pkg::*;
#(
   parameter int W       = 24,
   parameter int STYLE   = INC_SKIP,
   parameter int CHUNK_W = 6
) (
   input  logic [W-1:0] a_i,
   input  logic         inc_i,
   output logic [W-1:0] y_o,
   output logic         carry_o
);

   localparam int NCH = (W + CHUNK_W - 1) / CHUNK_W;

   if (W < 2) begin : g_bad_w
      $error("rnd_incr: W must be at least 2");
   end
   if (CHUNK_W < 1) begin : g_bad_chunk
      $error("rnd_incr: CHUNK_W must be positive");
   end
   if (STYLE != INC_RIPPLE && STYLE != INC_SKIP) begin : g_bad_style
      $error("rnd_incr: unknown STYLE");
   end

   if (STYLE == INC_RIPPLE) begin : g_ripple
      logic [W:0] c;
      assign c[0] = inc_i;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign y_o[i]  = a_i[i] ^ c[i];
         assign c[i+1]  = a_i[i] & c[i];
      end
      assign carry_o = c[W];
   end else begin : g_skip
      logic [NCH:0] cc;
      assign cc[0] = inc_i;
      for (genvar k = 0; k < NCH; k++) begin : g_chunk
         localparam int LO = k * CHUNK_W;
         localparam int HI = (LO + CHUNK_W > W) ? (W - 1) : (LO + CHUNK_W - 1);
         localparam int SW = HI - LO + 1;
         logic [SW-1:0] seg;
         assign seg        = a_i[HI:LO];
         assign y_o[HI:LO] = seg + SW'(cc[k]);
         assign cc[k+1]    = cc[k] & (&seg);
      end
      assign carry_o = cc[NCH];
   end

   always_comb begin
      AST_INC_SUM: assert (y_o == a_i + W'(inc_i));                   // R7
      AST_CARRY_ZERO: assert (!carry_o || (y_o == '0 && inc_i));      // R7
   end

endmodule

// File: rtl/rnd_ovf_dir.sv
module rnd_ovf_dir
   import mant_round_pkg::*;
(
   input  logic       sign_i,
   input  logic [1:0] rmode_i,
   output logic       to_inf_o
);

   rmode_e mode;
   assign mode = rmode_e'(rmode_i);

   always_comb begin
      to_inf_o = 1'b1;
      unique case (mode)
         RMODE_NEAREST: to_inf_o = 1'b1;
         RMODE_ZERO:    to_inf_o = 1'b0;
         RMODE_POS:     to_inf_o = ~sign_i;
         RMODE_NEG:     to_inf_o = sign_i;
         default:       to_inf_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/mant_round.sv
module mant_round
   import mant_round_pkg::*;
#(
   parameter int MANT_W    = 26,
   parameter int INC_STYLE = INC_SKIP,
   parameter int CHUNK_W   = 6
) (
   input  logic              sign_i,
   input  logic [MANT_W-1:0] mant_i,
   input  logic              sticky_i,
   input  logic [1:0]        rmode_i,
   output logic [MANT_W-3:0] rounded_o,
   output logic              rnd_up_o,
   output logic              inexact_o,
   output logic              ovf_inf_o
);

   localparam int OUT_W = MANT_W - 2;

   if (MANT_W < 4) begin : g_bad_mant
      $error("mant_round: MANT_W must be at least 4");
   end

   logic [OUT_W-1:0] shifted;
   logic             bump;
   logic             inc_carry;

   assign shifted = mant_i[MANT_W-1:2];

   rnd_decide u_decide (
      .sign_i    (sign_i),
      .guard_i   (mant_i[1]),
      .round_i   (mant_i[0]),
      .sticky_i  (sticky_i),
      .lsb_i     (mant_i[2]),
      .rmode_i   (rmode_i),
      .bump_o    (bump),
      .inexact_o (inexact_o)
   );

   rnd_incr #(
      .W       (OUT_W),
      .STYLE   (INC_STYLE),
      .CHUNK_W (CHUNK_W)
   ) u_incr (
      .a_i     (shifted),
      .inc_i   (bump),
      .y_o     (rounded_o),
      .carry_o (inc_carry)
   );

   rnd_ovf_dir u_ovf (
      .sign_i   (sign_i),
      .rmode_i  (rmode_i),
      .to_inf_o (ovf_inf_o)
   );

   assign rnd_up_o = bump;

   always_comb begin
      AST_NO_BUMP_EXACT: assert (inexact_o || (rounded_o == shifted));      // R2
      AST_UP_FLAG:       assert (rnd_up_o == (rounded_o != shifted));       // R9
      AST_WRAP_ONLY_ONES: assert (!inc_carry || (&shifted));                // R7
      AST_OVF_NEAR:      assert (rmode_i != 2'd0 || ovf_inf_o);             // R8
      AST_OVF_ZERO:      assert (rmode_i != 2'd1 || !ovf_inf_o);            // R8
   end

endmodule

// File: tb/mant_round_test.sv
module mant_round_test;

   localparam int MANT_W = 26;
   localparam int OUT_W  = MANT_W - 2;

   typedef struct {
      logic [OUT_W-1:0] mant;
      logic             up;
      logic             inx;
      logic             ovf;
      string            tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sign_i = 1'b0;
   logic [MANT_W-1:0] mant_i = '0;
   logic              sticky_i = 1'b0;
   logic [1:0]        rmode_i = 2'd0;
   logic [OUT_W-1:0]  rounded_o;
   logic              rnd_up_o, inexact_o, ovf_inf_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   exp_t q[$];

   always #10 clk = ~clk;   // 50 MHz

   mant_round uut (
      .sign_i    (sign_i),
      .mant_i    (mant_i),
      .sticky_i  (sticky_i),
      .rmode_i   (rmode_i),
      .rounded_o (rounded_o),
      .rnd_up_o  (rnd_up_o),
      .inexact_o (inexact_o),
      .ovf_inf_o (ovf_inf_o)
   );

   // Driver: applies stimulus after a rising edge and queues the expectation
   task automatic drive(input logic s, input logic [OUT_W-1:0] hi,
                        input logic g, input logic r, input logic st,
                        input logic [1:0] md, input string tag);
      exp_t e;
      logic lost, inc;
      @(posedge clk);
      #1;
      sign_i   = s;
      mant_i   = {hi, g, r};
      sticky_i = st;
      rmode_i  = md;
      lost = g | r | st;
      case (md)
         2'd0: inc = g & (r | st | hi[0]);
         2'd1: inc = 1'b0;
         2'd2: inc = lost & ~s;
         default: inc = lost & s;
      endcase
      e.mant = hi + OUT_W'(inc);
      e.up   = inc;
      e.inx  = lost;
      e.ovf  = (md == 2'd0) ? 1'b1 : (md == 2'd1) ? 1'b0 : (md == 2'd2) ? ~s : s;
      e.tag  = tag;
      q.push_back(e);
   endtask

   // Monitor: compares on the falling edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         total++;
         if (rounded_o !== e.mant || rnd_up_o !== e.up ||
             inexact_o !== e.inx || ovf_inf_o !== e.ovf) begin
            bad++;
            $display("FAIL %s: got mant=%h up=%b inx=%b ovf=%b exp mant=%h up=%b inx=%b ovf=%b",
                     e.tag, rounded_o, rnd_up_o, inexact_o, ovf_inf_o,
                     e.mant, e.up, e.inx, e.ovf);
         end
      end
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // reset-time state: all inputs zero
      drive(1'b0, 24'h000000, 1'b0, 1'b0, 1'b0, 2'd0, "R1 reset zero");
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      // R1 / R2 exact values, every mode
      drive(1'b0, 24'hABCDEF, 1'b0, 1'b0, 1'b0, 2'd0, "R2 exact nearest");
      drive(1'b1, 24'h800001, 1'b0, 1'b0, 1'b0, 2'd1, "R2 exact zero");
      drive(1'b0, 24'h123457, 1'b0, 1'b0, 1'b0, 2'd2, "R2 exact pos");
      drive(1'b1, 24'hFFFFFF, 1'b0, 1'b0, 1'b0, 2'd3, "R2 exact neg");
      // R4 nearest: ties and non-ties
      drive(1'b0, 24'h800000, 1'b1, 1'b0, 1'b0, 2'd0, "R4 tie even stays");
      drive(1'b0, 24'h800001, 1'b1, 1'b0, 1'b0, 2'd0, "R4 tie odd bumps");
      drive(1'b1, 24'h800000, 1'b1, 1'b1, 1'b0, 2'd0, "R4 above half");
      drive(1'b0, 24'h800000, 1'b1, 1'b0, 1'b1, 2'd0, "R4 sticky breaks tie");
      drive(1'b0, 24'h800001, 1'b0, 1'b1, 1'b1, 2'd0, "R4 below half");
      // R3 inexact from each source; R5 toward zero
      drive(1'b0, 24'h9ABCDE, 1'b1, 1'b1, 1'b1, 2'd1, "R5 zero all set");
      drive(1'b1, 24'h000001, 1'b0, 1'b0, 1'b1, 2'd1, "R3 sticky only");
      drive(1'b0, 24'h000002, 1'b0, 1'b1, 1'b0, 2'd0, "R3 round only");
      // R6 directed modes, both signs
      drive(1'b0, 24'h400000, 1'b0, 1'b0, 1'b1, 2'd2, "R6 pos positive");
      drive(1'b1, 24'h400000, 1'b0, 1'b0, 1'b1, 2'd2, "R6 pos negative");
      drive(1'b1, 24'h400000, 1'b0, 1'b1, 1'b0, 2'd3, "R6 neg negative");
      drive(1'b0, 24'h400000, 1'b1, 1'b0, 1'b0, 2'd3, "R6 neg positive");
      // R7 long carries
      drive(1'b0, 24'h7FFFFF, 1'b1, 1'b1, 1'b0, 2'd0, "R7 carry to 2.0");
      drive(1'b0, 24'hFFFFFF, 1'b1, 1'b0, 1'b0, 2'd0, "R7 wrap all ones");
      drive(1'b1, 24'h00003F, 1'b0, 1'b0, 1'b1, 2'd3, "R7 chunk boundary");
      drive(1'b0, 24'h000FFF, 1'b0, 1'b1, 1'b0, 2'd2, "R9 up flag carry");
      // R8 overflow direction, all mode/sign pairs
      for (int m = 0; m < 4; m++) begin
         for (int s = 0; s < 2; s++) begin
            drive(s[0], 24'h5A5A5A, 1'b0, 1'b0, 1'b0, m[1:0], "R8 ovf direction");
         end
      end
      @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule